// File: doc/BRIEF.md
# Composable SDRAM Pattern Sequencer

This block is the command back-end of a real-time SDRAM controller. Each accepted request is a fixed-size read or write access, carrying a direction, a bank, a row and a column. The block answers it by replaying a stored command pattern, one entry per clock, toward the PHY. Two patterns are kept, one for reads and one for writes. Both are loaded at run time through a small memory-mapped port.

Both patterns share one programmable length. The dead cycles needed to turn the data bus around are padded into the patterns themselves. As a result, every slot lasts the same number of cycles and starts on a fixed grid, whatever the direction of the access before it. When no request is waiting at a slot boundary, the block spends one whole slot issuing NOPs so that the grid never moves. Loading patterns with different command spacing trades worst-case bandwidth against latency and power.

The controller has two named states. FILL covers a slot of NOPs; reset enters it. ACCESS covers a slot that replays a pattern. The transitions all happen in the last cycle of a slot:
- FILL_TO_ACCESS: a request is waiting.
- FILL_TO_FILL: nothing is waiting.
- ACCESS_TO_ACCESS: a back-to-back request is waiting.
- ACCESS_TO_FILL: nothing is waiting.

Top module: `sdram_pattern_seq`

## Requirements
- R1: After reset, the block issues NOP with all address fields zero, holds `cfg_ready` high and `req_ready` low, and first raises `req_ready` LEN_RST-1 cycles after reset is released.
- R2: `cmd_o` uses the codes NOP=0, ACT=1, RD=2, WR=3 and PRE=4. A pattern entry whose command field holds 5, 6 or 7 is issued as NOP.
- R3: `req_ready` is high exactly in the last cycle of each slot, and a request is accepted when `req_valid` and `req_ready` are high together. Entry i of the selected pattern appears on the command outputs i cycles after the clock edge that accepts the request. Entries at or beyond the active length are never issued.
- R4: Every slot, whether read, write or fill, lasts exactly the active length. The accepting edges of back-to-back requests are therefore one length apart.
- R5: `req_dir`=0 selects the read pattern and `req_dir`=1 selects the write pattern.
- R6: A pattern entry is 5 bits wide: the command code sits in bits [4:2] and a column step in bits [1:0]. Fields are filled in as follows:
  - ACT carries the request bank and row, with column 0.
  - RD and WR carry the request bank, row 0, and the request column plus step×8, modulo the column width.
  - PRE carries the bank only.
  - NOP carries all fields zero.
- R7: If no request is waiting at a slot boundary, the next slot is all NOPs and `cfg_ready` stays high for the whole slot.
- R8: `cfg_ready` is low throughout an access slot, and a configuration write made while it is low has no effect.
- R9: The configuration address is {region[1:0], index}:
  - region 0 writes read-pattern entry `index`.
  - region 1 writes write-pattern entry `index`.
  - region 2 writes the length from the low bits of `cfg_wdata`.
  - region 3 is ignored.
- R10: A length write of 0, or of more than DEPTH, is ignored. An accepted length applies to slots that start after the write.
- R11: A pattern entry written in a fill slot is used by every access that starts after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | High in the last cycle of a slot; the request is taken then |
| req_dir | input | 1 | 0 read, 1 write |
| req_bank | input | BA_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Base column of the access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ready | output | 1 | Configuration writes are taken (fill slot) |
| cfg_addr | input | log2(DEPTH)+2 | {region, index} |
| cfg_wdata | input | max(5, log2(DEPTH+1)) | Pattern entry or length value |
| cmd_o | output | 3 | Command to the PHY |
| cmd_bank | output | BA_W | Bank field of the command |
| cmd_row | output | ROW_W | Row field of the command |
| cmd_col | output | COL_W | Column field of the command |

## Verification
The bench builds the block with DEPTH=16 and LEN_RST=8, using a 3-bit bank, a 13-bit row and a 10-bit column. The default length is therefore short enough that back-to-back slots, an inserted fill slot and the first boundary after reset all fall within a few dozen cycles. A 5-bit length field makes the out-of-range value 17 expressible, which exercises the rejection of illegal lengths. An entry parked at index 12 is never reached at length 8 or length 10, which checks that replay stops at the active length.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic {
        SLOT_FILL,
        SLOT_ACCESS
    } slot_state_e;

    localparam logic [1:0] REGION_RDPAT = 2'd0;
    localparam logic [1:0] REGION_WRPAT = 2'd1;
    localparam logic [1:0] REGION_LEN   = 2'd2;

endpackage

// File: rtl/seq_pattern_store.sv
module seq_pattern_store #(
    parameter int DEPTH   = 32,
    parameter int ENTRY_W = 5,
    parameter int IDX_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_dir,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               rd_dir,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] rd_q [2];

    // One entry array per direction: index 0 read, index 1 write.
    for (genvar g = 0; g < 2; g++) begin : g_dir
        logic [ENTRY_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= '0;
                end
            end else if (wr_en && (wr_dir == 1'(g)) && (int'(wr_idx) < DEPTH)) begin
                mem[wr_idx] <= wr_data;
            end
        end

        assign rd_q[g] = mem[rd_idx];
    end

    assign rd_data = rd_q[rd_dir];

endmodule

// File: rtl/seq_slot_timer.sv
module seq_slot_timer
    import sdram_seq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int LEN_RST = 16,
    parameter int LEN_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_wdata,
    output slot_state_e      state,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] len_act,
    output logic             boundary
);

    slot_state_e      state_nxt;
    logic [LEN_W-1:0] len_prog;
    logic [LEN_W-1:0] len_prog_nxt;
    logic             len_ok;

    assign len_ok       = len_we && (len_wdata != '0) && (len_wdata <= LEN_W'(DEPTH));
    assign len_prog_nxt = len_ok ? len_wdata : len_prog;
    assign boundary     = (cnt == len_act - 1'b1);

    always_comb begin
        state_nxt = state;
        unique case (state)
            SLOT_FILL: begin
                if (boundary && req_valid) state_nxt = SLOT_ACCESS;   // FILL_TO_ACCESS
                else                       state_nxt = SLOT_FILL;     // FILL_TO_FILL
            end
            SLOT_ACCESS: begin
                if (boundary && !req_valid) state_nxt = SLOT_FILL;    // ACCESS_TO_FILL
                else                        state_nxt = SLOT_ACCESS;  // ACCESS_TO_ACCESS
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SLOT_FILL;
            cnt      <= '0;
            len_prog <= LEN_W'(LEN_RST);
            len_act  <= LEN_W'(LEN_RST);
        end else begin
            state    <= state_nxt;
            cnt      <= boundary ? '0 : cnt + 1'b1;
            len_prog <= len_prog_nxt;
            if (boundary) begin
                len_act <= len_prog_nxt;
            end
        end
    end

endmodule

// File: rtl/seq_cmd_former.sv
module seq_cmd_former
    import sdram_seq_pkg::*;
#(
    parameter int BA_W    = 3,
    parameter int ROW_W   = 14,
    parameter int COL_W   = 10,
    parameter int OFS_W   = 2,
    parameter int STEP_SH = 3
) (
    input  logic                   active,
    input  logic [CMD_W+OFS_W-1:0] entry,
    input  logic [BA_W-1:0]        bank,
    input  logic [ROW_W-1:0]       row,
    input  logic [COL_W-1:0]       col,
    output logic [CMD_W-1:0]       cmd,
    output logic [BA_W-1:0]        cmd_bank,
    output logic [ROW_W-1:0]       cmd_row,
    output logic [COL_W-1:0]       cmd_col
);

    logic [CMD_W-1:0] code;
    logic [OFS_W-1:0] ofs;

    assign code = entry[CMD_W+OFS_W-1:OFS_W];
    assign ofs  = entry[OFS_W-1:0];

    always_comb begin
        cmd      = CMD_NOP;
        cmd_bank = '0;
        cmd_row  = '0;
        cmd_col  = '0;
        if (active) begin
            case (code)
                CMD_ACT: begin
                    cmd      = CMD_ACT;
                    cmd_bank = bank;
                    cmd_row  = row;
                end
                CMD_RD, CMD_WR: begin
                    cmd      = code;
                    cmd_bank = bank;
                    cmd_col  = col + (COL_W'(ofs) << STEP_SH);
                end
                CMD_PRE: begin
                    cmd      = CMD_PRE;
                    cmd_bank = bank;
                end
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdram_pattern_seq.sv
module sdram_pattern_seq
    import sdram_seq_pkg::*;
#(
    parameter int BA_W    = 3,
    parameter int ROW_W   = 14,
    parameter int COL_W   = 10,
    parameter int DEPTH   = 32,
    parameter int OFS_W   = 2,
    parameter int STEP_SH = 3,
    parameter int LEN_RST = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_dir,
    input  logic [BA_W-1:0]             req_bank,
    input  logic [ROW_W-1:0]            req_row,
    input  logic [COL_W-1:0]            req_col,
    input  logic                        cfg_we,
    output logic                        cfg_ready,
    input  logic [$clog2(DEPTH)+1:0]    cfg_addr,
    input  logic [((3+OFS_W) > $clog2(DEPTH+1) ? (3+OFS_W) : $clog2(DEPTH+1))-1:0] cfg_wdata,
    output logic [2:0]                  cmd_o,
    output logic [BA_W-1:0]             cmd_bank,
    output logic [ROW_W-1:0]            cmd_row,
    output logic [COL_W-1:0]            cmd_col
);

    localparam int IDX_W   = $clog2(DEPTH);
    localparam int LEN_W   = $clog2(DEPTH + 1);
    localparam int ENTRY_W = CMD_W + OFS_W;

    slot_state_e       state;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  len_act;
    logic              boundary;

    logic              acc_dir;
    logic [BA_W-1:0]   acc_bank;
    logic [ROW_W-1:0]  acc_row;
    logic [COL_W-1:0]  acc_col;

    logic [1:0]         cfg_region;
    logic               cfg_take;
    logic               pat_we;
    logic               len_we;
    logic [ENTRY_W-1:0] entry;

    assign cfg_ready  = (state == SLOT_FILL);
    assign req_ready  = boundary;
    assign cfg_region = cfg_addr[IDX_W+1:IDX_W];
    assign cfg_take   = cfg_we && cfg_ready;
    assign pat_we     = cfg_take && ((cfg_region == REGION_RDPAT) || (cfg_region == REGION_WRPAT));
    assign len_we     = cfg_take && (cfg_region == REGION_LEN);

    // Request fields held for the whole access slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_dir  <= 1'b0;
            acc_bank <= '0;
            acc_row  <= '0;
            acc_col  <= '0;
        end else if (req_valid && req_ready) begin
            acc_dir  <= req_dir;
            acc_bank <= req_bank;
            acc_row  <= req_row;
            acc_col  <= req_col;
        end
    end

    seq_slot_timer #(
        .DEPTH   (DEPTH),
        .LEN_RST (LEN_RST),
        .LEN_W   (LEN_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .len_we    (len_we),
        .len_wdata (cfg_wdata[LEN_W-1:0]),
        .state     (state),
        .cnt       (cnt),
        .len_act   (len_act),
        .boundary  (boundary)
    );

    seq_pattern_store #(
        .DEPTH   (DEPTH),
        .ENTRY_W (ENTRY_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pat_we),
        .wr_dir  (cfg_region[0]),
        .wr_idx  (cfg_addr[IDX_W-1:0]),
        .wr_data (cfg_wdata[ENTRY_W-1:0]),
        .rd_dir  (acc_dir),
        .rd_idx  (IDX_W'(cnt)),
        .rd_data (entry)
    );

    seq_cmd_former #(
        .BA_W    (BA_W),
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .OFS_W   (OFS_W),
        .STEP_SH (STEP_SH)
    ) u_former (
        .active   (state == SLOT_ACCESS),
        .entry    (entry),
        .bank     (acc_bank),
        .row      (acc_row),
        .col      (acc_col),
        .cmd      (cmd_o),
        .cmd_bank (cmd_bank),
        .cmd_row  (cmd_row),
        .cmd_col  (cmd_col)
    );

endmodule

// File: rtl/sdram_pattern_seq_chk.sv
module sdram_pattern_seq_chk #(
    parameter int DEPTH = 32,
    parameter int LEN_W = 6,
    parameter int BA_W  = 3,
    parameter int ROW_W = 14,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cfg_ready,
    input logic [2:0]       cmd_o,
    input logic [BA_W-1:0]  cmd_bank,
    input logic [ROW_W-1:0] cmd_row,
    input logic [COL_W-1:0] cmd_col,
    input logic [LEN_W-1:0] len_act
);

    // Independent count of cycles since reset or since the last slot end.
    logic [LEN_W-1:0] gap;
    always_ff @(posedge clk) begin
        if (!rst_n)         gap <= '0;
        else if (req_ready) gap <= '0;
        else                gap <= gap + 1'b1;
    end

    p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o <= 3'd4);

    p_slot_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (gap == len_act - 1'b1));

    p_gap_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gap < len_act);

    p_nop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd0) |-> (cmd_bank == '0 && cmd_row == '0 && cmd_col == '0));

    p_rdwr_row_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd2 || cmd_o == 3'd3) |-> (cmd_row == '0));

    p_pre_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd4) |-> (cmd_row == '0 && cmd_col == '0));

    p_fill_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> (cmd_o == 3'd0));

    p_idle_to_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> cfg_ready);

    p_accept_to_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !cfg_ready);

    p_len_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (len_act != '0) && (len_act <= LEN_W'(DEPTH)));

endmodule

bind sdram_pattern_seq sdram_pattern_seq_chk #(
    .DEPTH (DEPTH),
    .LEN_W ($clog2(DEPTH + 1)),
    .BA_W  (BA_W),
    .ROW_W (ROW_W),
    .COL_W (COL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cfg_ready (cfg_ready),
    .cmd_o     (cmd_o),
    .cmd_bank  (cmd_bank),
    .cmd_row   (cmd_row),
    .cmd_col   (cmd_col),
    .len_act   (len_act)
);

// File: tb/sdram_pattern_seq_test.sv
`timescale 1ns/1ps
module sdram_pattern_seq_test;

    localparam int DEPTH   = 16;
    localparam int LEN_RST = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_dir = 1'b0;
    logic [2:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_ready;
    logic [5:0]  cfg_addr = '0;
    logic [4:0]  cfg_wdata = '0;
    logic [2:0]  cmd_o;
    logic [2:0]  cmd_bank;
    logic [12:0] cmd_row;
    logic [9:0]  cmd_col;

    always #2.5 clk = ~clk;

    sdram_pattern_seq #(
        .BA_W(3), .ROW_W(13), .COL_W(10), .DEPTH(DEPTH),
        .OFS_W(2), .STEP_SH(3), .LEN_RST(LEN_RST)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_dir(req_dir),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cfg_we(cfg_we), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cmd_o(cmd_o), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
    );

    typedef struct {
        int          cyc;
        logic [2:0]  cmd;
        logic [2:0]  bank;
        logic [12:0] row;
        logic [9:0]  col;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    int         bench_len = LEN_RST;
    logic [4:0] rd_pat [DEPTH];
    logic [4:0] wr_pat [DEPTH];
    bit         done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [4:0] ent(input logic [2:0] c, input logic [1:0] o);
        return {c, o};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(input int c, input logic [2:0] cm, input logic [2:0] b,
                        input logic [12:0] r, input logic [9:0] co);
        exp_t e;
        e.cyc = c; e.cmd = cm; e.bank = b; e.row = r; e.col = co;
        sb.push_back(e);
    endtask

    // Driver: presents a request, waits for the slot end, queues the expected commands.
    task automatic do_req(input logic d, input logic [2:0] b, input logic [12:0] r,
                          input logic [9:0] co, output int k);
        req_valid = 1'b1; req_dir = d; req_bank = b; req_row = r; req_col = co;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        k = cyc + 1;
        for (int i = 0; i < bench_len; i++) begin
            logic [4:0] e;
            logic [9:0] cc;
            e  = d ? wr_pat[i] : rd_pat[i];
            cc = co + 10'(e[1:0]) * 10'd8;
            case (e[4:2])
                3'd1:       push(k + i, 3'd1, b, r, '0);
                3'd2, 3'd3: push(k + i, e[4:2], b, '0, cc);
                3'd4:       push(k + i, 3'd4, b, '0, '0);
                default: ;
            endcase
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [1:0] reg_sel, input logic [3:0] idx, input logic [4:0] data);
        cfg_we = 1'b1; cfg_addr = {reg_sel, idx}; cfg_wdata = data;
        forever begin
            @(negedge clk);
            if (cfg_ready) break;
        end
        if (reg_sel == 2'd0) rd_pat[idx] = data;
        if (reg_sel == 2'd1) wr_pat[idx] = data;
        if (reg_sel == 2'd2 && data != 0 && data <= DEPTH) bench_len = data;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic cfg_blocked(input logic [1:0] reg_sel, input logic [3:0] idx, input logic [4:0] data);
        @(negedge clk);
        check(cfg_ready == 1'b0, "R8 cfg_ready low in access slot", cfg_ready, 0);
        cfg_we = 1'b1; cfg_addr = {reg_sel, idx}; cfg_wdata = data;
        @(posedge clk);
        #1 cfg_we = 1'b0;
    endtask

    task automatic wait_fill();
        forever begin
            @(negedge clk);
            if (cfg_ready) break;
        end
    endtask

    // Monitor: compares every non-NOP command with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].cyc < cyc) begin
                errors++; checks++;
                $display("FAIL R3 missing command actual=none expected=%0d at cycle %0d", sb[0].cmd, sb[0].cyc);
                void'(sb.pop_front());
            end
            if (cmd_o != 3'd0) begin
                checks++;
                if (sb.size() == 0 || sb[0].cyc != cyc) begin
                    errors++;
                    $display("FAIL R2 R3 unexpected command actual=%0d expected=0 at cycle %0d", cmd_o, cyc);
                end else begin
                    if (cmd_o != sb[0].cmd || cmd_bank != sb[0].bank ||
                        cmd_row != sb[0].row || cmd_col != sb[0].col) begin
                        errors++;
                        $display("FAIL R5 R6 actual=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                                 cmd_o, cmd_bank, cmd_row, cmd_col,
                                 sb[0].cmd, sb[0].bank, sb[0].row, sb[0].col);
                    end
                    void'(sb.pop_front());
                end
            end else if (sb.size() > 0 && sb[0].cyc == cyc) begin
                errors++; checks++;
                $display("FAIL R3 NOP issued actual=0 expected=%0d", sb[0].cmd);
                void'(sb.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ka, kb, kc, kd, ke, kf, kg, kh, n;
        for (int i = 0; i < DEPTH; i++) begin
            rd_pat[i] = '0;
            wr_pat[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state and first slot boundary
        @(negedge clk);
        check(cmd_o == 3'd0 && cmd_bank == 0 && cmd_row == 0 && cmd_col == 0, "R1 NOP after reset", cmd_o, 0);
        check(cfg_ready == 1'b1, "R1 cfg_ready after reset", cfg_ready, 1);
        check(req_ready == 1'b0, "R1 req_ready after reset", req_ready, 0);
        n = 0;
        while (!req_ready) begin
            @(negedge clk);
            n++;
        end
        check(n == LEN_RST - 1, "R1 first boundary", n, LEN_RST - 1);

        // Program patterns (R9 regions 0 and 1); code 5 is an R2 case
        cfg_write(2'd0, 4'd0, ent(3'd1, 2'd0));
        cfg_write(2'd0, 4'd2, ent(3'd2, 2'd0));
        cfg_write(2'd0, 4'd3, ent(3'd2, 2'd1));
        cfg_write(2'd0, 4'd6, ent(3'd4, 2'd0));
        cfg_write(2'd0, 4'd7, ent(3'd5, 2'd0));
        cfg_write(2'd0, 4'd12, ent(3'd1, 2'd0));
        cfg_write(2'd1, 4'd0, ent(3'd1, 2'd0));
        cfg_write(2'd1, 4'd1, ent(3'd3, 2'd0));
        cfg_write(2'd1, 4'd2, ent(3'd3, 2'd2));
        cfg_write(2'd1, 4'd5, ent(3'd4, 2'd0));

        // R4 R5: back-to-back read then write
        do_req(1'b0, 3'd2, 13'd100, 10'd64, ka);
        do_req(1'b1, 3'd5, 13'd7, 10'd16, kb);
        check(kb - ka == 8, "R4 back-to-back spacing", kb - ka, 8);

        // R8: writes during the access slot are ignored
        cfg_blocked(2'd0, 4'd2, ent(3'd3, 2'd0));
        cfg_blocked(2'd2, 4'd0, 5'd4);

        // R7: fill slot of NOPs, late request waits for the next boundary
        repeat (11) @(negedge clk);
        check(cmd_o == 3'd0 && cfg_ready == 1'b1, "R7 fill slot NOP", cmd_o, 0);
        cfg_write(2'd3, 4'd2, ent(3'd1, 2'd0));   // R9 region 3 ignored
        cfg_write(2'd1, 4'd2, ent(3'd3, 2'd3));   // R11 rewrite applied next access
        do_req(1'b0, 3'd1, 13'd4095, 10'd1000, kc);
        check(kc - kb == 16, "R7 fill slot inserted", kc - kb, 16);
        do_req(1'b1, 3'd3, 13'd55, 10'd1020, kd);
        check(kd - kc == 8, "R4 read to write spacing", kd - kc, 8);

        // R10: illegal lengths ignored
        wait_fill();
        cfg_write(2'd2, 4'd0, 5'd0);
        cfg_write(2'd2, 4'd0, 5'd17);
        do_req(1'b0, 3'd6, 13'd9, 10'd0, ke);
        do_req(1'b1, 3'd6, 13'd9, 10'd8, kf);
        check(kf - ke == 8, "R10 illegal length ignored", kf - ke, 8);

        // R10: legal length takes effect from the next slot
        wait_fill();
        cfg_write(2'd2, 4'd0, 5'd10);
        do_req(1'b0, 3'd0, 13'd1, 10'd2, kg);
        do_req(1'b1, 3'd7, 13'd2, 10'd3, kh);
        check(kh - kg == 10, "R10 new length spacing", kh - kg, 10);

        repeat (14) @(negedge clk);
        check(sb.size() == 0, "R3 all expected commands issued", sb.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule